// File: doc/BRIEF.md
# Configurable RAM Error Protection Unit

This block sits on the 64-bit path between a processor and a local RAM. On the write side it turns each doubleword into a set of check bits that the RAM stores next to the data. On the read side it takes the data and the stored check bits back, compares them, and either flags the mismatch or repairs it. The corrected data and the error flags come out together, one clock after the read is presented.

The strength of protection is fixed when the block is built. There are three choices. Byte parity uses 8 check bits. A single-error-correct, double-error-detect (SECDED) code applied to each 32-bit half uses 14 check bits. One SECDED code over the whole doubleword uses 8 check bits. At run time two inputs shape the response. One turns checking off entirely. The other picks between repairing a correctable error and only reporting it. Parity polarity is set by a static pin.

Both SECDED variants use a Hamming code extended by one overall-parity bit. Check bit j covers every codeword position whose binary index has bit j set. The data bits fill the positions that are not powers of two, in ascending order. The overall bit sits at the top of each group.

Top module: `ramprot_unit`

## Requirements
- R1: In parity builds, bit i of `wr_chk` is the XOR of `wr_data[8i+7:8i]`, inverted when `cfg_odd` is 1. It appears one clock after `wr_data`.
- R2: In parity builds, a read in which any byte disagrees with its parity bit raises `err_ue` and returns the data unmodified. An even number of flips inside one byte raises no flag.
- R3: In 32-bit-word SECDED builds, `wr_chk[6:0]` protects bits 31:0 and `wr_chk[13:7]` protects bits 63:32. One flip in a word is corrected and raises `err_ce`. Two flips in one word raise `err_ue` and leave that word raw. The flags of the two words are ORed.
- R4: In doubleword SECDED builds, any single flip among the 64 data bits and 8 check bits is corrected and raises `err_ce` only.
- R5: In doubleword SECDED builds, any two flips raise `err_ue` without `err_ce`, and the raw data is returned.
- R6: When `chk_en` is 0, the read data passes through unchanged and no flag is raised. Check bits are still generated on the write side.
- R7: When `fix_en` is 0, a correctable error still raises `err_ce`, but the raw data is returned.
- R8: `out_valid`, `out_data`, `err_ce` and `err_ue` are registered one clock after `rd_valid`/`rd_data`. The flags are only ever raised together with `out_valid`.
- R9: While `rst` is high, at each clock all outputs are driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_odd | input | 1 | Static parity polarity: 1 selects odd parity |
| chk_en | input | 1 | Enables read checking |
| fix_en | input | 1 | Enables repair of correctable errors |
| wr_data | input | DW | Doubleword being written |
| wr_chk | output | CW | Registered check bits for `wr_data` |
| rd_valid | input | 1 | Read data present this cycle |
| rd_data | input | DW | Doubleword read from RAM |
| rd_chk | input | CW | Check bits read from RAM |
| out_valid | output | 1 | Registered `rd_valid` |
| out_data | output | DW | Corrected or raw read data |
| err_ce | output | 1 | Correctable error seen on this read |
| err_ue | output | 1 | Uncorrectable (or parity) error seen on this read |

## Verification
Each scheme is tried with clean codewords and with single flips placed in the lowest data bit, in the highest data bit, in a Hamming check bit and in the overall bit. Together these show that repair reaches every kind of position, and that a flip confined to the check bits never alters the data. Double flips are tried as two data bits, as a data bit plus a check bit, and as two check bits, to separate detection from miscorrection. The word-split build is given flips in both halves, so that independent correction can be told apart from a shared syndrome. The parity build is given single flips in every byte, a double flip in one byte and a parity-bit flip, which show its blind spot.

// File: rtl/ramprot_pkg.sv
package ramprot_pkg;

  localparam int SCH_PARITY = 0;
  localparam int SCH_W32    = 1;
  localparam int SCH_W64    = 2;

  // Hamming bits needed so that 2**r covers k data + r check positions
  function automatic int ham_bits(input int k);
    int r;
    r = 1;
    while ((1 << r) < k + r + 1) r++;
    return r;
  endfunction

  // Codeword position (1-based) of data bit idx: non-power-of-two slots
  function automatic int data_pos(input int idx);
    int p;
    int n;
    p = 0;
    n = -1;
    while (n < idx) begin
      p++;
      if ((p & (p - 1)) != 0) n++;
    end
    return p;
  endfunction

  // Total check width for a scheme over dw data bits
  function automatic int chk_width(input int scheme, input int dw);
    case (scheme)
      SCH_PARITY: return dw / 8;
      SCH_W32:    return 2 * (ham_bits(dw / 2) + 1);
      default:    return ham_bits(dw) + 1;
    endcase
  endfunction

endpackage

// File: rtl/ramprot_parity.sv
module ramprot_parity #(
  parameter int DW = 64
) (
  input  logic [DW-1:0]   enc_d,
  input  logic            odd,
  output logic [DW/8-1:0] enc_p,
  input  logic [DW-1:0]   dec_d,
  input  logic [DW/8-1:0] dec_p,
  output logic            dec_bad
);
  localparam int NB = DW / 8;

  logic [NB-1:0] mism;

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      enc_p[b] = (^enc_d[8*b +: 8]) ^ odd;
      mism[b]  = (^dec_d[8*b +: 8]) ^ dec_p[b] ^ odd;
    end
  end

  assign dec_bad = |mism;

endmodule

// File: rtl/ramprot_secded.sv
module ramprot_secded
  import ramprot_pkg::*;
#(
  parameter int K = 64
) (
  input  logic [K-1:0]         enc_d,
  output logic [ham_bits(K):0] enc_c,
  input  logic [K-1:0]         dec_d,
  input  logic [ham_bits(K):0] dec_c,
  output logic [K-1:0]         dec_fixed,
  output logic                 dec_single,
  output logic                 dec_double
);
  localparam int R = ham_bits(K);
  localparam int N = K + R;

  function automatic logic [R-1:0] ham(input logic [K-1:0] d);
    logic [R-1:0] h;
    int p;
    h = '0;
    for (int i = 0; i < K; i++) begin
      p = data_pos(i);
      for (int j = 0; j < R; j++)
        if (((p >> j) & 1) != 0) h[j] = h[j] ^ d[i];
    end
    return h;
  endfunction

  logic [R-1:0] enc_h;
  logic [R-1:0] syn;
  logic         ovr;
  logic         in_range;

  always_comb begin
    enc_h = ham(enc_d);
    enc_c = {(^enc_d) ^ (^enc_h), enc_h};
  end

  always_comb begin
    syn      = ham(dec_d) ^ dec_c[R-1:0];
    ovr      = (^dec_d) ^ (^dec_c);
    in_range = (int'(syn) <= N);
    dec_single = ovr && in_range;
    dec_double = (!ovr && (syn != '0)) || (ovr && !in_range);
    for (int i = 0; i < K; i++)
      dec_fixed[i] = dec_d[i] ^ (dec_single && (int'(syn) == data_pos(i)));
  end

endmodule

// File: rtl/ramprot_unit.sv
module ramprot_unit
  import ramprot_pkg::*;
#(
  parameter int SCHEME = SCH_W64,
  parameter int DW     = 64
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_odd,
  input  logic                             chk_en,
  input  logic                             fix_en,
  input  logic [DW-1:0]                    wr_data,
  output logic [chk_width(SCHEME, DW)-1:0] wr_chk,
  input  logic                             rd_valid,
  input  logic [DW-1:0]                    rd_data,
  input  logic [chk_width(SCHEME, DW)-1:0] rd_chk,
  output logic                             out_valid,
  output logic [DW-1:0]                    out_data,
  output logic                             err_ce,
  output logic                             err_ue
);
  localparam int CW    = chk_width(SCHEME, DW);
  localparam int WORDS = (SCHEME == SCH_W32) ? 2 : 1;
  localparam int WK    = DW / WORDS;
  localparam int WC    = ham_bits(WK) + 1;

  logic [CW-1:0] enc_c;
  logic [DW-1:0] fix_c;
  logic          ce_c;
  logic          ue_c;

  generate
    if (SCHEME == SCH_PARITY) begin : g_par
      logic bad;
      ramprot_parity #(.DW(DW)) u_par (
        .enc_d  (wr_data),
        .odd    (cfg_odd),
        .enc_p  (enc_c),
        .dec_d  (rd_data),
        .dec_p  (rd_chk),
        .dec_bad(bad)
      );
      assign fix_c = rd_data;
      assign ce_c  = 1'b0;
      assign ue_c  = bad;
    end else begin : g_ecc
      logic [WORDS-1:0] sgl;
      logic [WORDS-1:0] dbl;
      for (genvar w = 0; w < WORDS; w++) begin : g_word
        ramprot_secded #(.K(WK)) u_code (
          .enc_d     (wr_data[w*WK +: WK]),
          .enc_c     (enc_c[w*WC +: WC]),
          .dec_d     (rd_data[w*WK +: WK]),
          .dec_c     (rd_chk[w*WC +: WC]),
          .dec_fixed (fix_c[w*WK +: WK]),
          .dec_single(sgl[w]),
          .dec_double(dbl[w])
        );
      end
      assign ce_c = |sgl;
      assign ue_c = |dbl;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_chk    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      err_ce    <= 1'b0;
      err_ue    <= 1'b0;
    end else begin
      wr_chk    <= enc_c;
      out_valid <= rd_valid;
      out_data  <= (chk_en && fix_en) ? fix_c : rd_data;
      err_ce    <= rd_valid && chk_en && ce_c;
      err_ue    <= rd_valid && chk_en && ue_c;
    end
  end

endmodule

// File: rtl/ramprot_unit_chk.sv
module ramprot_unit_chk #(
  parameter int SCHEME = 2,
  parameter int DW     = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          chk_en,
  input logic          fix_en,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          err_ce,
  input logic          err_ue
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R8
  out_valid_lat_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    out_valid == $past(rd_valid));

  // R8
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !(err_ce || err_ue));

  // R6
  check_off_raw_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(!chk_en) |-> (out_data == $past(rd_data) && !err_ce && !err_ue));

  // R7
  report_only_raw_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(!fix_en) |-> out_data == $past(rd_data));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !err_ce && !err_ue && out_data == '0));

  generate
    if (SCHEME != 1) begin : g_excl
      // R5
      flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(err_ce && err_ue));
    end
  endgenerate

endmodule

bind ramprot_unit ramprot_unit_chk #(.SCHEME(SCHEME), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .chk_en   (chk_en),
  .fix_en   (fix_en),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .out_valid(out_valid),
  .out_data (out_data),
  .err_ce   (err_ce),
  .err_ue   (err_ue)
);

// File: tb/ramprot_unit_tb.sv
module ramprot_unit_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        cfg_odd = 1'b0;
  logic        chk_en  = 1'b1;
  logic        fix_en  = 1'b1;
  logic        rd_valid = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data = '0;
  logic [7:0]  rc64 = '0;
  logic [13:0] rc32 = '0;
  logic [7:0]  rcp  = '0;

  logic [7:0]  wc64;
  logic [13:0] wc32;
  logic [7:0]  wcp;
  logic        ov64, ce64, ue64, ov32, ce32, ue32, ovp, cep, uep;
  logic [63:0] od64, od32, odp;

  ramprot_unit #(.SCHEME(2)) u_dut (
    .clk(clk), .rst(rst), .cfg_odd(cfg_odd), .chk_en(chk_en), .fix_en(fix_en),
    .wr_data(wr_data), .wr_chk(wc64), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_chk(rc64), .out_valid(ov64), .out_data(od64), .err_ce(ce64), .err_ue(ue64));

  ramprot_unit #(.SCHEME(1)) u_e32 (
    .clk(clk), .rst(rst), .cfg_odd(cfg_odd), .chk_en(chk_en), .fix_en(fix_en),
    .wr_data(wr_data), .wr_chk(wc32), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_chk(rc32), .out_valid(ov32), .out_data(od32), .err_ce(ce32), .err_ue(ue32));

  ramprot_unit #(.SCHEME(0)) u_par (
    .clk(clk), .rst(rst), .cfg_odd(cfg_odd), .chk_en(chk_en), .fix_en(fix_en),
    .wr_data(wr_data), .wr_chk(wcp), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_chk(rcp), .out_valid(ovp), .out_data(odp), .err_ce(cep), .err_ue(uep));

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0]  e64;
  logic [13:0] e32;
  logic [7:0]  ep;

  typedef struct packed {
    logic [63:0] d;
    logic [63:0] df;
    logic [7:0]  cf;
    logic        ce;
    logic        ue;
  } vec_t;

  // Doubleword SECDED vectors: data, data flips, check flips, expected flags
  localparam vec_t VECS [8] = '{
    '{64'h0123_4567_89AB_CDEF, 64'h0,                   8'h00, 1'b0, 1'b0},
    '{64'h0123_4567_89AB_CDEF, 64'h1,                   8'h00, 1'b1, 1'b0},
    '{64'hFFFF_0000_FFFF_0000, 64'h8000_0000_0000_0000, 8'h00, 1'b1, 1'b0},
    '{64'hDEAD_BEEF_0BAD_F00D, 64'h0,                   8'h80, 1'b1, 1'b0},
    '{64'hA5A5_5A5A_3C3C_C3C3, 64'h0,                   8'h01, 1'b1, 1'b0},
    '{64'h1111_2222_3333_4444, 64'h0000_0100_0000_0020, 8'h00, 1'b0, 1'b1},
    '{64'h0,                   64'h400,                 8'h04, 1'b0, 1'b1},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0,                   8'hC0, 1'b0, 1'b1}
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic encode(input logic [63:0] d);
    @(negedge clk);
    wr_data = d;
    @(negedge clk);
    e64 = wc64;
    e32 = wc32;
    ep  = wcp;
  endtask

  task automatic read(input logic v, input logic [63:0] d, input logic [7:0] c64,
                      input logic [13:0] c32, input logic [7:0] cp);
    @(negedge clk);
    rd_valid = v;
    rd_data  = d;
    rc64 = c64;
    rc32 = c32;
    rcp  = cp;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [7:0]  pexp;

    // R9: reset dominates a live read
    rd_valid = 1'b1;
    rd_data  = 64'hFFFF_FFFF_FFFF_FFFF;
    wr_data  = 64'h1234;
    repeat (3) @(negedge clk);
    check("R9", "out_valid", {63'b0, ov64}, 64'h0);
    check("R9", "flags", {62'b0, ce64, ue64}, 64'h0);
    check("R9", "out_data", od64, 64'h0);
    check("R9", "wr_chk", {56'b0, wc64}, 64'h0);
    rd_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;

    // R4 R5: table walk over the doubleword code
    for (int i = 0; i < 8; i++) begin
      encode(VECS[i].d);
      read(1'b1, VECS[i].d ^ VECS[i].df, e64 ^ VECS[i].cf, e32, ep);
      check(VECS[i].ue ? "R5" : "R4", "data", od64,
            VECS[i].ue ? (VECS[i].d ^ VECS[i].df) : VECS[i].d);
      check(VECS[i].ue ? "R5" : "R4", "ce", {63'b0, ce64}, {63'b0, VECS[i].ce});
      check(VECS[i].ue ? "R5" : "R4", "ue", {63'b0, ue64}, {63'b0, VECS[i].ue});
      check("R8", "out_valid", {63'b0, ov64}, 64'h1);
    end

    // R1: parity polarity
    d = 64'h0123_4567_89AB_CDEF;
    for (int o = 0; o < 2; o++) begin
      cfg_odd = o[0];
      encode(d);
      for (int b = 0; b < 8; b++) pexp[b] = (^d[8*b +: 8]) ^ o[0];
      check("R1", "parity bits", {56'b0, ep}, {56'b0, pexp});
    end

    // R2: parity detection and its blind spot
    cfg_odd = 1'b0;
    encode(d);
    read(1'b1, d ^ 64'h0101_0101_0101_0101, e64, e32, ep);
    check("R2", "ue one flip per byte", {63'b0, uep}, 64'h1);
    check("R2", "raw data", odp, d ^ 64'h0101_0101_0101_0101);
    read(1'b1, d ^ 64'h3, e64, e32, ep);
    check("R2", "two flips in one byte", {62'b0, cep, uep}, 64'h0);
    read(1'b1, d, e64, e32, ep ^ 8'h10);
    check("R2", "parity bit flip", {63'b0, uep}, 64'h1);
    check("R2", "data intact", odp, d);

    // R3: per-word SECDED
    d = 64'hCAFE_F00D_1234_5678;
    encode(d);
    read(1'b1, d ^ 64'h0000_0100_0000_0008, e64, e32, ep);
    check("R3", "one flip per word data", od32, d);
    check("R3", "one flip per word flags", {62'b0, ce32, ue32}, 64'h2);
    read(1'b1, d ^ 64'h88, e64, e32, ep);
    check("R3", "double in word0 flags", {62'b0, ce32, ue32}, 64'h1);
    check("R3", "double in word0 data", od32, d ^ 64'h88);
    read(1'b1, d ^ 64'h0000_0006_0000_0008, e64, e32, ep);
    check("R3", "mixed flags", {62'b0, ce32, ue32}, 64'h3);
    check("R3", "mixed data", od32, d ^ 64'h0000_0006_0000_0000);
    read(1'b1, d, e64, e32 ^ 14'h0080, ep);
    check("R3", "upper check flip", {62'b0, ce32, ue32}, 64'h2);
    check("R3", "upper check flip data", od32, d);

    // R6: checking off
    chk_en = 1'b0;
    read(1'b1, d ^ 64'h1, e64 ^ 8'h03, e32, ep);
    check("R6", "raw data", od64, d ^ 64'h1);
    check("R6", "no flags", {62'b0, ce64, ue64}, 64'h0);
    d = 64'h0F0F_F0F0_5555_AAAA;
    encode(d);
    chk_en = 1'b1;
    read(1'b1, d ^ 64'h200, e64, e32, ep);
    check("R6", "check bits made while off", od64, d);
    check("R6", "ce after re-enable", {62'b0, ce64, ue64}, 64'h2);

    // R7: report only
    fix_en = 1'b0;
    read(1'b1, d ^ 64'h0010_0000, e64, e32, ep);
    check("R7", "raw data", od64, d ^ 64'h0010_0000);
    check("R7", "ce still flagged", {62'b0, ce64, ue64}, 64'h2);
    fix_en = 1'b1;

    // R8: no read, no flags
    read(1'b0, d ^ 64'h3, e64, e32, ep);
    check("R8", "idle valid", {63'b0, ov64}, 64'h0);
    check("R8", "idle flags", {62'b0, ce64, ue64}, 64'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule